// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block prepares the second operand of an arithmetic/logic unit within the same cycle as the operation that consumes it. It accepts either a compact 12-bit immediate or a full-width register value. It returns the prepared operand together with a shifter carry, which the ALU can use for its carry flag on logical operations.

In immediate form, the low eight bits of the field are zero-extended. The value is then rotated right by twice the upper four bits, so it can land at any of sixteen even positions. In register form, the value is shifted by a 5-bit amount using one of six shift types. Rotate-with-extend ignores the amount and moves the incoming carry into the top bit. Both forms share one logarithmic barrel structure, and the whole path is combinational, so no cycle is added in front of the ALU.

Top module: `bshift_operand_unit`

## Requirements
- R1: With `imm_sel`=1, `operand_out` equals `{24'b0, imm_field[7:0]}` rotated right by 2*`imm_field[11:8]` positions.
- R2: With `imm_sel`=1, `carry_out` equals `carry_in` when `imm_field[11:8]` is 0; otherwise it equals bit 31 of `operand_out`.
- R3: Shift type codes 3'b000 (logical left) and 3'b001 (arithmetic left) give identical results. For amount n in 1..31, the output is the register value shifted left by n with zeros in, and `carry_out` is input bit 32-n.
- R4: Code 3'b010 (logical right) shifts right by n with zeros in the top n bits, and `carry_out` is input bit n-1.
- R5: Code 3'b011 (arithmetic right) shifts right by n, fills the top n bits with input bit 31, and `carry_out` is input bit n-1.
- R6: Code 3'b100 (rotate right) rotates right by n, and `carry_out` is input bit n-1, which equals output bit 31.
- R7: Code 3'b101 (rotate right with extend) ignores `shift_amt`. It outputs `{carry_in, reg_val[31:1]}`, and `carry_out` is `reg_val[0]`.
- R8: For codes 3'b000 to 3'b100 with `shift_amt`=0, `operand_out` equals `reg_val` and `carry_out` equals `carry_in`.
- R9: Codes 3'b110 and 3'b111 pass `reg_val` through unchanged, with `carry_out` equal to `carry_in`.
- R10: With `imm_sel`=1, `reg_val`, `shift_type` and `shift_amt` have no effect on either output.
- R11: The path holds no state: the outputs follow the inputs within the same cycle, with no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_sel | input | 1 | 1 selects the immediate form, 0 the register form |
| imm_field | input | 12 | [7:0] value, [11:8] rotate count in steps of two |
| reg_val | input | 32 | Register operand for the register form |
| shift_type | input | 3 | Shift type code (see R3 to R9) |
| shift_amt | input | 5 | Shift amount for the register form |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Prepared second operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The block holds no state. A fault therefore shows at the ports in the cycle when the affected input combination is applied: a wrong stage of the barrel corrupts every amount that has that bit set, and a wrong carry index shows on every nonzero amount of that type. The bench samples at the opposite clock edge to the one where it drives. It uses boundary amounts (0, 1, 31), every rotate count and a pseudo-random sweep, so each stage and each fill choice is exercised on its own.

// File: rtl/bshift_pkg.sv
// Package: shared encodings for the second-operand shifter.
// Assumes the consumer decodes shift type codes as listed here.
package bshift_pkg;

    // Shift type codes presented on shift_type.
    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_ASL = 3'd1,
        SH_LSR = 3'd2,
        SH_ASR = 3'd3,
        SH_ROR = 3'd4,
        SH_RRX = 3'd5
    } shift_e;

    // Fill choice for the vacated bits of a right barrel stage.
    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_ROT  = 2'd2
    } fill_e;

endpackage

// File: rtl/bshift_barrel.sv
// Module: logarithmic right barrel with selectable fill.
// Shifts din right by amt, in one stage per amount bit.
// Assumes DATA_W == 2**AMT_W. Sign fill copies din's top bit.
module bshift_barrel #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    input  bshift_pkg::fill_e fill,
    output logic [DATA_W-1:0] dout
);
    import bshift_pkg::*;

    logic [DATA_W-1:0] stage [0:AMT_W];

    assign stage[0] = din;

    generate
        for (genvar k = 0; k < AMT_W; k++) begin : g_stage
            localparam int DIST = 1 << k;
            logic [DIST-1:0] top_fill;
            // Selects the bits that enter from the top in this stage.
            assign top_fill = (fill == FILL_ROT)  ? stage[k][DIST-1:0] :
                              (fill == FILL_SIGN) ? {DIST{din[DATA_W-1]}} :
                                                    {DIST{1'b0}};
            // Applies this stage's shift when its amount bit is set.
            assign stage[k+1] = amt[k] ? {top_fill, stage[k][DATA_W-1:DIST]}
                                       : stage[k];
        end
    endgenerate

    assign dout = stage[AMT_W];

endmodule

// File: rtl/bshift_imm_path.sv
// Module: immediate operand former.
// Zero-extends the low field and rotates it right by twice the rotate field.
// Assumes ROT_W + 1 == AMT_W, so a doubled count spans the word.
module bshift_imm_path #(
    parameter int DATA_W = 32,
    parameter int VAL_W  = 8,
    parameter int ROT_W  = 4,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [VAL_W+ROT_W-1:0] imm_field,
    input  logic                   carry_in,
    output logic [DATA_W-1:0]      imm_out,
    output logic                   imm_carry
);
    import bshift_pkg::*;

    logic [ROT_W-1:0]  rot_cnt;
    logic [AMT_W-1:0]  rot_amt;
    logic [DATA_W-1:0] ext_val;

    assign rot_cnt = imm_field[VAL_W+ROT_W-1:VAL_W];
    assign rot_amt = AMT_W'({rot_cnt, 1'b0});
    assign ext_val = {{(DATA_W-VAL_W){1'b0}}, imm_field[VAL_W-1:0]};

    bshift_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) rot_i (
        .din  (ext_val),
        .amt  (rot_amt),
        .fill (FILL_ROT),
        .dout (imm_out)
    );

    // Carry keeps its value when no rotation happens.
    assign imm_carry = (rot_cnt == '0) ? carry_in : imm_out[DATA_W-1];

endmodule

// File: rtl/bshift_reg_path.sv
// Module: register operand shifter.
// Applies left, right, arithmetic, rotate and extend-rotate shifts.
// Left shifts reuse the right barrel on bit-reversed data.
// Assumes DATA_W == 2**AMT_W. Unused codes pass the value through.
module bshift_reg_path #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] reg_val,
    input  logic [2:0]        shift_type,
    input  logic [AMT_W-1:0]  shift_amt,
    input  logic              carry_in,
    output logic [DATA_W-1:0] reg_out,
    output logic              reg_carry
);
    import bshift_pkg::*;

    logic              is_left;
    logic              is_barrel;
    fill_e             fill_sel;
    logic [DATA_W-1:0] bar_in;
    logic [DATA_W-1:0] bar_out;
    logic [DATA_W-1:0] bar_fix;
    logic [AMT_W-1:0]  left_idx;
    logic [AMT_W-1:0]  right_idx;
    logic              shifted_carry;

    // Reverses bit order so that a right barrel performs a left shift.
    function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
        for (int i = 0; i < DATA_W; i++) bit_rev[i] = v[DATA_W-1-i];
    endfunction

    // Decodes shift type into direction and fill choice.
    always_comb begin
        is_left   = 1'b0;
        is_barrel = 1'b1;
        fill_sel  = FILL_ZERO;
        case (shift_type)
            SH_LSL, SH_ASL: is_left  = 1'b1;
            SH_LSR:         fill_sel = FILL_ZERO;
            SH_ASR:         fill_sel = FILL_SIGN;
            SH_ROR:         fill_sel = FILL_ROT;
            default:        is_barrel = 1'b0;
        endcase
    end

    assign bar_in = is_left ? bit_rev(reg_val) : reg_val;

    bshift_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) shf_i (
        .din  (bar_in),
        .amt  (shift_amt),
        .fill (fill_sel),
        .dout (bar_out)
    );

    assign bar_fix   = is_left ? bit_rev(bar_out) : bar_out;
    assign left_idx  = AMT_W'(~shift_amt + 1'b1);
    assign right_idx = shift_amt - 1'b1;
    assign shifted_carry = is_left ? reg_val[left_idx] : reg_val[right_idx];

    // Selects the result and carry for the decoded shift type.
    always_comb begin
        if (shift_type == SH_RRX) begin
            reg_out   = {carry_in, reg_val[DATA_W-1:1]};
            reg_carry = reg_val[0];
        end else if (!is_barrel) begin
            reg_out   = reg_val;
            reg_carry = carry_in;
        end else begin
            reg_out   = bar_fix;
            reg_carry = (shift_amt == '0) ? carry_in : shifted_carry;
        end
    end

endmodule

// File: rtl/bshift_operand_unit.sv
// Module: second-operand barrel shifter, top level.
// Selects between the immediate former and the register shifter.
// Purely combinational; assumes the ALU consumes the result in this cycle.
module bshift_operand_unit #(
    parameter int DATA_W = 32,
    parameter int VAL_W  = 8,
    parameter int ROT_W  = 4,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic                   imm_sel,
    input  logic [VAL_W+ROT_W-1:0] imm_field,
    input  logic [DATA_W-1:0]      reg_val,
    input  logic [2:0]             shift_type,
    input  logic [AMT_W-1:0]       shift_amt,
    input  logic                   carry_in,
    output logic [DATA_W-1:0]      operand_out,
    output logic                   carry_out
);
    logic [DATA_W-1:0] imm_out;
    logic              imm_carry;
    logic [DATA_W-1:0] reg_out;
    logic              reg_carry;

    bshift_imm_path #(
        .DATA_W(DATA_W), .VAL_W(VAL_W), .ROT_W(ROT_W), .AMT_W(AMT_W)
    ) imm_i (
        .imm_field (imm_field),
        .carry_in  (carry_in),
        .imm_out   (imm_out),
        .imm_carry (imm_carry)
    );

    bshift_reg_path #(.DATA_W(DATA_W), .AMT_W(AMT_W)) reg_i (
        .reg_val    (reg_val),
        .shift_type (shift_type),
        .shift_amt  (shift_amt),
        .carry_in   (carry_in),
        .reg_out    (reg_out),
        .reg_carry  (reg_carry)
    );

    // Chooses the operand form requested by the instruction.
    assign operand_out = imm_sel ? imm_out   : reg_out;
    assign carry_out   = imm_sel ? imm_carry : reg_carry;

endmodule

// File: rtl/bshift_operand_chk.sv
// Checker: port-level properties of the second-operand shifter.
// Uses immediate assertions because the block has no clock.
module bshift_operand_chk #(
    parameter int DATA_W = 32,
    parameter int VAL_W  = 8,
    parameter int ROT_W  = 4,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input logic                   imm_sel,
    input logic [VAL_W+ROT_W-1:0] imm_field,
    input logic [DATA_W-1:0]      reg_val,
    input logic [2:0]             shift_type,
    input logic [AMT_W-1:0]       shift_amt,
    input logic                   carry_in,
    input logic [DATA_W-1:0]      operand_out,
    input logic                   carry_out
);
    // Checks each port relation whenever an input changes.
    always_comb begin
        if (imm_sel) begin
            assert_imm_bits_kept_R1: assert ($countones(operand_out) ==
                                             $countones(imm_field[VAL_W-1:0]))
                else $error("R1 immediate bit count changed");
        end else begin
            if (shift_type <= 3'd4 && shift_amt == '0) begin
                assert_zero_amt_pass_R8: assert (operand_out == reg_val &&
                                                 carry_out == carry_in)
                    else $error("R8 zero amount not passed through");
            end
            if (shift_type <= 3'd1 && shift_amt != '0) begin
                assert_left_zero_in_R3: assert (operand_out[0] == 1'b0)
                    else $error("R3 left shift did not insert zero");
            end
            if (shift_type == 3'd3) begin
                assert_asr_sign_kept_R5: assert (operand_out[DATA_W-1] == reg_val[DATA_W-1])
                    else $error("R5 sign not kept");
            end
            if (shift_type == 3'd4) begin
                assert_ror_bits_kept_R6: assert ($countones(operand_out) == $countones(reg_val))
                    else $error("R6 rotate lost bits");
            end
            if (shift_type == 3'd5) begin
                assert_rrx_form_R7: assert (operand_out[DATA_W-1] == carry_in &&
                                            carry_out == reg_val[0])
                    else $error("R7 extend rotate wrong");
            end
            if (shift_type >= 3'd6) begin
                assert_unused_pass_R9: assert (operand_out == reg_val && carry_out == carry_in)
                    else $error("R9 unused code not passed through");
            end
        end
    end

endmodule

bind bshift_operand_unit bshift_operand_chk #(
    .DATA_W(DATA_W), .VAL_W(VAL_W), .ROT_W(ROT_W), .AMT_W(AMT_W)
) chk_i (
    .imm_sel     (imm_sel),
    .imm_field   (imm_field),
    .reg_val     (reg_val),
    .shift_type  (shift_type),
    .shift_amt   (shift_amt),
    .carry_in    (carry_in),
    .operand_out (operand_out),
    .carry_out   (carry_out)
);

// File: tb/bshift_operand_unit_tb_top.sv
// Bench: scoreboard for the second-operand shifter.
// The driver applies a vector at a rising edge and queues the expected result.
// The monitor compares at the following falling edge (R11: same cycle).
module bshift_operand_unit_tb_top;

    typedef struct {
        logic [31:0] res;
        logic        cout;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        imm_sel = 1'b0;
    logic [11:0] imm_field = '0;
    logic [31:0] reg_val = '0;
    logic [2:0]  shift_type = '0;
    logic [4:0]  shift_amt = '0;
    logic        carry_in = 1'b0;
    logic [31:0] operand_out;
    logic        carry_out;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    bshift_operand_unit dut_i (
        .imm_sel     (imm_sel),
        .imm_field   (imm_field),
        .reg_val     (reg_val),
        .shift_type  (shift_type),
        .shift_amt   (shift_amt),
        .carry_in    (carry_in),
        .operand_out (operand_out),
        .carry_out   (carry_out)
    );

    // Reference model: one bit per step, taken from the requirements.
    function automatic exp_t model(input logic sel, input logic [11:0] imm,
                                   input logic [31:0] rv, input logic [2:0] ty,
                                   input logic [4:0] amt, input logic cin);
        exp_t e;
        logic [31:0] x;
        logic c;
        c = cin;
        if (sel) begin
            x = {24'b0, imm[7:0]};
            for (int i = 0; i < 2 * int'(imm[11:8]); i++) x = {x[0], x[31:1]};
            if (imm[11:8] != 0) c = x[31];
            e.tag = "R1 R2";
        end else begin
            x = rv;
            case (ty)
                3'd0, 3'd1: begin
                    for (int i = 0; i < int'(amt); i++) begin c = x[31]; x = {x[30:0], 1'b0}; end
                    e.tag = (amt == 0) ? "R8" : "R3";
                end
                3'd2: begin
                    for (int i = 0; i < int'(amt); i++) begin c = x[0]; x = {1'b0, x[31:1]}; end
                    e.tag = (amt == 0) ? "R8" : "R4";
                end
                3'd3: begin
                    for (int i = 0; i < int'(amt); i++) begin c = x[0]; x = {x[31], x[31:1]}; end
                    e.tag = (amt == 0) ? "R8" : "R5";
                end
                3'd4: begin
                    for (int i = 0; i < int'(amt); i++) begin c = x[0]; x = {x[0], x[31:1]}; end
                    e.tag = (amt == 0) ? "R8" : "R6";
                end
                3'd5: begin
                    c = rv[0]; x = {cin, rv[31:1]};
                    e.tag = "R7";
                end
                default: e.tag = "R9";
            endcase
        end
        e.res = x;
        e.cout = c;
        return e;
    endfunction

    // Driver: applies one vector and queues its expected result.
    task automatic apply(input logic sel, input logic [11:0] imm, input logic [31:0] rv,
                         input logic [2:0] ty, input logic [4:0] amt, input logic cin,
                         input string tag_override);
        exp_t e;
        @(posedge clk);
        imm_sel = sel; imm_field = imm; reg_val = rv;
        shift_type = ty; shift_amt = amt; carry_in = cin;
        e = model(sel, imm, rv, ty, amt, cin);
        if (tag_override != "") e.tag = tag_override;
        sb_q.push_back(e);
    endtask

    // Monitor: compares the outputs away from the driving edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (operand_out !== e.res || carry_out !== e.cout) begin
                n_fail++;
                $display("FAIL %s: got %h/%b expected %h/%b", e.tag,
                         operand_out, carry_out, e.res, e.cout);
            end
        end
    end

    // Watchdog: counts a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog R11: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Stimulus: directed corners, then a pseudo-random sweep.
    initial begin
        logic [31:0] lfsr;
        lfsr = 32'hACE1_2468;
        // Idle state with all-zero inputs (register form, LSL by 0).
        apply(0, 12'h000, 32'h0, 3'd0, 5'd0, 1'b0, "R8");
        // R1 R2: every rotate count, including 0 and 15.
        for (int r = 0; r < 16; r++) begin
            apply(1, {4'(r), 8'hA5}, 32'h0, 3'd0, 5'd0, 1'b1, "");
            apply(1, {4'(r), 8'h81}, 32'h0, 3'd0, 5'd0, 1'b0, "");
        end
        // R3 to R8: boundary amounts for each barrel type.
        for (int t = 0; t < 5; t++) begin
            apply(0, 12'h0, 32'h8000_0001, 3'(t), 5'd0,  1'b1, "");
            apply(0, 12'h0, 32'h8000_0001, 3'(t), 5'd1,  1'b0, "");
            apply(0, 12'h0, 32'hC000_0003, 3'(t), 5'd31, 1'b1, "");
            apply(0, 12'h0, 32'h7FFF_FFFE, 3'(t), 5'd16, 1'b0, "");
        end
        // R5: a positive value fills with zeros, a negative one with ones.
        apply(0, 12'h0, 32'h4000_0000, 3'd3, 5'd30, 1'b0, "R5");
        apply(0, 12'h0, 32'hF000_0000, 3'd3, 5'd31, 1'b0, "R5");
        // R7: the amount is ignored.
        apply(0, 12'h0, 32'h0000_0003, 3'd5, 5'd0,  1'b1, "R7");
        apply(0, 12'h0, 32'h0000_0002, 3'd5, 5'd17, 1'b0, "R7");
        // R9: unused codes.
        apply(0, 12'h0, 32'hDEAD_BEEF, 3'd6, 5'd5, 1'b1, "R9");
        apply(0, 12'h0, 32'h1234_5678, 3'd7, 5'd9, 1'b0, "R9");
        // R10: register-side inputs change while the immediate stays fixed.
        apply(1, 12'h3C7, 32'h0,         3'd0, 5'd0,  1'b1, "R10");
        apply(1, 12'h3C7, 32'hFFFF_FFFF, 3'd3, 5'd31, 1'b1, "R10");
        apply(1, 12'h3C7, 32'h5555_AAAA, 3'd5, 5'd7,  1'b1, "R10");
        // R11: back-to-back vectors, each checked within its own cycle.
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(lfsr[3], lfsr[31:20], {lfsr[15:0], lfsr[31:16]} ^ 32'h9E37_79B9,
                  lfsr[6:4], lfsr[11:7], lfsr[12], "");
        end
        wait (sb_q.size() == 0);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule